// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block measures how many master clock cycles fit into one period of an incoming left/right frame clock and decides which of the supported master-clock-to-sample-rate multiples is in use. It runs entirely in the master clock domain and serves an audio serial port whose frame clock is an input. The frame clock is brought into the master clock domain through a two-flop synchroniser. Each rising frame edge closes one measurement period.

The set of accepted multiples depends on two control inputs. One selects whether the serial port feeds a converter in the capture (ADC) direction or the playback (DAC) direction. The other selects the playback oversampling mode. A period whose count is more than 32 cycles away from every accepted multiple is invalid. An invalid period drops lock and raises a hold command, which tells the serial port to stop and keep its output at the last good sample. Lock returns only after two consecutive periods classify to the same multiple.

The block has no data path, so there is no valid/ready interface and no back-pressure to handle. All pins are plain control and status signals.

Top module: `mclk_ratio_detector`

## Requirements
- R1: While reset is held and after its release until the first measurement, `ratio_code_o` is 7, `locked_o` is 0 and `hold_o` is 1.
- R2: Ratio codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 and 6=1152. Code 7 means no match. A period of N cycles matches a multiple M when |N-M| <= 32, with both limits inclusive.
- R3: With `path_dac_i`=0, only 256, 384, 512 and 768 are accepted, whatever the value of `osr64_i`.
- R4: With `path_dac_i`=1 and `osr64_i`=0, only 256, 384, 512, 768 and 1152 are accepted.
- R5: With `path_dac_i`=1 and `osr64_i`=1, only 128 and 192 are accepted. A count of 160 falls inside both windows and resolves to the lower multiple (code 0).
- R6: An invalid period sets `ratio_code_o` to 7, clears `locked_o` and sets `hold_o`.
- R7: `locked_o` rises only when two consecutive periods classify to the same multiple. A valid period with a different multiple clears `locked_o` and reports the new code. In that case `hold_o` keeps its value, and `hold_o` clears only when lock is reached.
- R8: The period counter saturates at 2047. If 2047 cycles pass without a frame edge, that is treated as an invalid period (see R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_clk_i | input | 1 | Left/right frame clock, asynchronous to the master clock |
| path_dac_i | input | 1 | 0: capture path, 1: playback path |
| osr64_i | input | 1 | Playback oversampling mode: 0 = 128x, 1 = 64x |
| ratio_code_o | output | 3 | Code of the last classified period (see R2) |
| locked_o | output | 1 | Ratio stable over two consecutive periods |
| hold_o | output | 1 | Disable serial port and hold the last sample |

## Verification
The assertions check the following on every cycle:
- Lock and hold are never asserted together.
- The no-match code always comes with hold and never with lock.
- Lock cannot survive a change of code.
- Lock can only rise when the code repeats the previous one.

Only the bench scenarios can show:
- The numeric window edges.
- The accepted set for each combination of path and oversampling mode.
- The 160 tie-break.
- The timeout for a missing frame clock.
- The recovery after that timeout.

The bench checks these against its own classifier.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIOS = 7;
  localparam int CODE_W     = 3;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'd7;

  function automatic int ratio_of(input int idx);
    case (idx)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      4: return 512;
      5: return 768;
      default: return 1152;
    endcase
  endfunction

  function automatic logic ratio_allowed(input int idx, input logic dac, input logic osr64);
    int r;
    r = ratio_of(idx);
    if (dac && osr64) return (r <= 192);
    if (dac)          return (r >= 256);
    return (r >= 256) && (r <= 768);
  endfunction
endpackage

// File: rtl/mrd_sync.sv
module mrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  output logic             strobe_o,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_o <= 1'b0;
      period_o <= '0;
    end else begin
      strobe_o <= 1'b0;
      if (edge_i) begin
        strobe_o <= 1'b1;
        period_o <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
        cnt_q    <= '0;
      end else if (cnt_q == CNT_MAX - CNT_ONE) begin
        strobe_o <= 1'b1;
        period_o <= CNT_MAX;
        cnt_q    <= CNT_MAX;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
  import mrd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 32
) (
  input  logic              [CNT_W-1:0] period_i,
  input  logic                          dac_i,
  input  logic                          osr64_i,
  output logic              [CODE_W-1:0] code_o,
  output logic                           valid_o
);
  logic [NUM_RATIOS-1:0] hit;
  int meas;

  assign meas = int'(period_i);

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
    localparam int RATIO = ratio_of(g);
    assign hit[g] = ratio_allowed(g, dac_i, osr64_i) &&
                    (meas + TOL >= RATIO) && (meas <= RATIO + TOL);
  end

  always_comb begin
    code_o = CODE_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) code_o = CODE_W'(i);
    end
  end

  assign valid_o = |hit;
endmodule

// File: rtl/mclk_ratio_detector.sv
module mclk_ratio_detector
  import mrd_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mclk_i,
  input  logic              rst_ni,
  input  logic              frame_clk_i,
  input  logic              path_dac_i,
  input  logic              osr64_i,
  output logic [CODE_W-1:0] ratio_code_o,
  output logic              locked_o,
  output logic              hold_o
);
  logic             frame_s, frame_d;
  logic             rise;
  logic             meas_stb;
  logic [CNT_W-1:0] meas_len;
  logic [CODE_W-1:0] cls_code;
  logic             cls_valid;

  mrd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (mclk_i),
    .rst_ni(rst_ni),
    .d_i   (frame_clk_i),
    .q_o   (frame_s)
  );

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) frame_d <= 1'b0;
    else         frame_d <= frame_s;
  end

  assign rise = frame_s & ~frame_d;

  mrd_period_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (mclk_i),
    .rst_ni  (rst_ni),
    .edge_i  (rise),
    .strobe_o(meas_stb),
    .period_o(meas_len)
  );

  mrd_classifier #(.CNT_W(CNT_W), .TOL(TOL)) i_cls (
    .period_i(meas_len),
    .dac_i   (path_dac_i),
    .osr64_i (osr64_i),
    .code_o  (cls_code),
    .valid_o (cls_valid)
  );

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_code_o <= CODE_NONE;
      locked_o     <= 1'b0;
      hold_o       <= 1'b1;
    end else if (meas_stb) begin
      if (!cls_valid) begin
        ratio_code_o <= CODE_NONE;
        locked_o     <= 1'b0;
        hold_o       <= 1'b1;
      end else begin
        ratio_code_o <= cls_code;
        if (cls_code == ratio_code_o) begin
          locked_o <= 1'b1;
          hold_o   <= 1'b0;
        end else begin
          locked_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
  input logic       mclk_i,
  input logic       rst_ni,
  input logic [2:0] ratio_code_o,
  input logic       locked_o,
  input logic       hold_o
);
  // R6 / R7: lock and hold are never asserted together
  p_lock_excludes_hold_r7: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    locked_o |-> !hold_o);

  // R6: the no-match code always comes with hold
  p_none_holds_r6: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (ratio_code_o == 3'd7) |-> hold_o);

  // R6: the no-match code never comes with lock
  p_none_unlocked_r6: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (ratio_code_o == 3'd7) |-> !locked_o);

  // R7: lock only persists while the code stays the same
  p_lock_same_code_r7: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> (ratio_code_o == $past(ratio_code_o)));

  // R7: lock can only rise on a repeated code
  p_lock_needs_repeat_r7: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> (ratio_code_o == $past(ratio_code_o)));
endmodule

bind mclk_ratio_detector mrd_checker i_mrd_checker (
  .mclk_i      (mclk_i),
  .rst_ni      (rst_ni),
  .ratio_code_o(ratio_code_o),
  .locked_o    (locked_o),
  .hold_o      (hold_o)
);

// File: tb/test_mclk_ratio_detector.sv
`timescale 1ns/1ps
module test_mclk_ratio_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic       dac = 1'b0;
  logic       osr = 1'b0;
  logic [2:0] code;
  logic       lock;
  logic       hold;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  mclk_ratio_detector i_mclk_ratio_detector (
    .mclk_i      (clk),
    .rst_ni      (rst_n),
    .frame_clk_i (frame),
    .path_dac_i  (dac),
    .osr64_i     (osr),
    .ratio_code_o(code),
    .locked_o    (lock),
    .hold_o      (hold)
  );

  function automatic int expect_code(input int n, input bit d, input bit o);
    int tbl [7] = '{128, 192, 256, 384, 512, 768, 1152};
    for (int i = 0; i < 7; i++) begin
      bit ok;
      if (d && o)  ok = (tbl[i] <= 192);
      else if (d)  ok = (tbl[i] >= 256);
      else         ok = (tbl[i] >= 256) && (tbl[i] <= 768);
      if (ok && n >= tbl[i] - 32 && n <= tbl[i] + 32) return i;
    end
    return 7;
  endfunction

  task automatic check(input string req, input int ec, input bit el, input bit eh);
    n_run++;
    if (code !== 3'(ec) || lock !== el || hold !== eh) begin
      n_fail++;
      $display("FAIL %s: code=%0d lock=%0b hold=%0b, expected code=%0d lock=%0b hold=%0b",
               req, code, lock, hold, ec, el, eh);
    end
  endtask

  task automatic period(input int p);
    frame = 1'b1;
    repeat (p / 2) @(negedge clk);
    frame = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  task automatic run_and_check(input string req, input int p, input bit d, input bit o);
    int ec;
    dac = d;
    osr = o;
    repeat (3) period(p);
    ec = expect_code(p, d, o);
    check(req, ec, ec != 7, ec == 7);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1a2b3c4d);
    repeat (4) @(negedge clk);
    check("R1 in reset", 7, 0, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 7, 0, 1);

    run_and_check("R3 adc 256", 256, 0, 0);
    run_and_check("R2 upper edge 288", 288, 0, 0);
    run_and_check("R2 past upper edge 289", 289, 0, 0);
    run_and_check("R2 lower edge 224", 224, 0, 0);
    run_and_check("R2 past lower edge 223", 223, 0, 0);
    run_and_check("R3 adc rejects 1152", 1152, 0, 0);
    run_and_check("R3 adc ignores osr 768", 768, 0, 1);
    run_and_check("R4 dac 1152", 1152, 1, 0);
    run_and_check("R4 dac 1184", 1184, 1, 0);
    run_and_check("R4 dac rejects 128", 128, 1, 0);
    run_and_check("R5 dac64 192", 192, 1, 1);
    run_and_check("R5 tie 160", 160, 1, 1);
    run_and_check("R5 161", 161, 1, 1);
    run_and_check("R5 rejects 256", 256, 1, 1);
    run_and_check("R6 invalid 600", 600, 0, 0);

    // R7: ratio change while locked
    run_and_check("R7 lock 256", 256, 0, 0);
    period(384);
    period(384);
    check("R7 new ratio unlocks, hold stays low", 3, 0, 0);
    period(384);
    check("R7 relock on repeat", 3, 1, 0);

    // R8: missing frame clock
    frame = 1'b0;
    repeat (2100) @(negedge clk);
    check("R8 timeout", 7, 0, 1);
    period(512);
    period(512);
    check("R7 hold stays until lock", 4, 0, 1);
    period(512);
    check("R7 lock after recovery", 4, 1, 0);

    for (int t = 0; t < 16; t++) begin
      int tbl [7] = '{128, 192, 256, 384, 512, 768, 1152};
      int p;
      p = tbl[$urandom_range(6, 0)] + int'($urandom_range(80, 0)) - 40;
      run_and_check($sformatf("R2 random trial %0d", t), p,
                    1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule